// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A host offers a word with a valid/ready handshake. When the transmitter is idle it takes the word and sends a low start bit, then the data bits with the least significant first, then an optional parity bit, then a run of high stop bits. After that the line returns to its high idle level.

All bit timing comes from a baud tick input that pulses at sixteen times the bit rate, so a full bit lasts sixteen ticks and half a bit lasts eight. Three static configuration inputs choose the character length (7 or 8 bits), the parity mode and the stop length. The block samples them when it accepts a word, so a host may change them while a frame is being sent without harm. The block exports a busy level and a one-cycle pulse when a frame completes.

Top module: `sertx_top`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_line` is 1, `in_ready` is 1, `busy` is 0 and `frame_done` is 0.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From the next cycle until the frame ends, `in_ready` is 0 and `busy` is 1. Any `in_valid` or `in_data` presented during that time has no effect on the frame being sent.
- R3: The start bit (0) appears on `tx_line` in the cycle after acceptance and lasts `TICKS_PER_BIT` (16) ticks. A tick in the accept cycle is not counted. Every data bit and the parity bit also last 16 ticks.
- R4: Data bits follow the start bit with the least significant bit first. `cfg_len8` = 1 sends `in_data[7:0]` and `cfg_len8` = 0 sends only `in_data[6:0]`, so bit 7 never appears.
- R5: `cfg_parity` selects the parity bit: 2'b00 means none, 2'b01 means even (data ones plus the parity bit total an even count), 2'b10 means odd (that total is odd), and 2'b11 means none. When present, the parity bit comes right after the last data bit.
- R6: `cfg_stop` selects a high stop period after the last data or parity bit: 2'b00 gives one bit (16 ticks), 2'b01 gives one and a half bits (24 ticks), and 2'b10 or 2'b11 gives two bits (32 ticks).
- R7: `frame_done` is 1 for exactly one cycle, in the cycle after the edge that samples the last stop tick. In that same cycle `busy` falls to 0 and `in_ready` rises to 1.
- R8: The configuration inputs are sampled at acceptance. Changing them during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversample tick, 16 per bit |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| cfg_parity | input | 2 | Parity mode select |
| cfg_stop | input | 2 | Stop length select |
| in_valid | input | 1 | Host offers a word |
| in_data | input | 8 | Word to send |
| in_ready | output | 1 | Transmitter can accept |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench counts the ticks the design samples on rising edges, starting after the accept edge. Bit k holds from tick count 16k up to 16k+16, so each bit is checked on the falling edge after count 16k+8. The stop period is checked at its fourth tick, so the half-bit setting is covered. The start bit, `busy` and the drop of `in_ready` are due on the falling edge just after acceptance. `frame_done`, the return of `in_ready` and the fall of `busy` are due on the falling edge after the final stop tick, and the bench checks that `busy` is still high one tick earlier and that `frame_done` has cleared one cycle later. Tick spacing is random, so these checks count ticks and never assume a fixed number of clock cycles.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_OFF  = 2'd3
    } parity_e;

    typedef enum logic [1:0] {
        STP_ONE  = 2'd0,
        STP_HALF = 2'd1,
        STP_TWO  = 2'd2,
        STP_TWOX = 2'd3
    } stop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic    len8;
        parity_e parity;
        stop_e   stop;
    } frame_cfg_t;

    function automatic logic has_parity(input parity_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                         input logic len8,
                                         input parity_e p);
        logic ones;
        ones = ^(len8 ? d : {1'b0, d[CHAR_W-2:0]});
        return (p == PAR_ODD) ? ~ones : ones;
    endfunction

    function automatic int unsigned stop_len(input stop_e s, input int unsigned tpb);
        case (s)
            STP_ONE:  return tpb;
            STP_HALF: return tpb + tpb / 2;
            default:  return 2 * tpb;
        endcase
    endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_end
);
    logic [CNT_W-1:0] cnt_q;

    assign bit_end = !clear && tick && (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= bit_end ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [CHAR_W-1:0] data,
    input  frame_cfg_t        cfg,
    output logic              lsb,
    output logic              par_bit
);
    logic [CHAR_W-1:0] sr_q;
    logic              par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sr_q  <= data;
            par_q <= calc_parity(data, cfg.len8, cfg.parity);
        end else if (shift) begin
            sr_q  <= {1'b0, sr_q[CHAR_W-1:1]};
        end
    end

    assign lsb     = sr_q[0];
    assign par_bit = par_q;
endmodule

// File: rtl/sertx_fsm.sv
module sertx_fsm
    import sertx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  frame_cfg_t       cfg_in,
    input  logic             bit_end,
    output tx_state_e        state,
    output logic             in_ready,
    output logic             frame_done,
    output logic             load,
    output logic             shift,
    output logic             timer_clear,
    output logic [CNT_W-1:0] limit
);
    localparam int unsigned IDX_W = $clog2(CHAR_W);

    tx_state_e        state_q;
    frame_cfg_t       cfg_q;
    logic [IDX_W-1:0] idx_q;
    logic             done_q;
    logic [IDX_W-1:0] last_idx;
    logic             accept;

    assign accept      = in_valid && (state_q == ST_IDLE);
    assign last_idx    = cfg_q.len8 ? IDX_W'(CHAR_W - 1) : IDX_W'(CHAR_W - 2);
    assign load        = accept;
    assign shift       = (state_q == ST_DATA) && bit_end;
    assign timer_clear = (state_q == ST_IDLE);
    assign limit       = (state_q == ST_STOP) ? CNT_W'(stop_len(cfg_q.stop, TICKS_PER_BIT))
                                              : CNT_W'(TICKS_PER_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    cfg_q   <= cfg_in;
                    state_q <= ST_START;
                end
                ST_START: if (bit_end) begin
                    idx_q   <= '0;
                    state_q <= ST_DATA;
                end
                ST_DATA: if (bit_end) begin
                    if (idx_q == last_idx) begin
                        state_q <= has_parity(cfg_q.parity) ? ST_PARITY : ST_STOP;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_PARITY: if (bit_end) state_q <= ST_STOP;
                ST_STOP: if (bit_end) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state      = state_q;
    assign in_ready   = (state_q == ST_IDLE);
    assign frame_done = done_q;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       cfg_len8,
    input  logic [1:0] cfg_parity,
    input  logic [1:0] cfg_stop,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       tx_line,
    output logic       busy,
    output logic       frame_done
);
    localparam int unsigned CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

    frame_cfg_t       cfg_in;
    tx_state_e        state;
    logic             bit_end, load, shift, timer_clear, lsb, par_bit;
    logic [CNT_W-1:0] limit;

    assign cfg_in = '{len8: cfg_len8, parity: parity_e'(cfg_parity), stop: stop_e'(cfg_stop)};

    sertx_fsm #(.TICKS_PER_BIT(TICKS_PER_BIT), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_in(cfg_in),
        .bit_end(bit_end), .state(state), .in_ready(in_ready),
        .frame_done(frame_done), .load(load), .shift(shift),
        .timer_clear(timer_clear), .limit(limit)
    );

    sertx_bit_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .clear(timer_clear), .tick(tick),
        .limit(limit), .bit_end(bit_end)
    );

    sertx_shifter shift_i (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .data(in_data), .cfg(cfg_in), .lsb(lsb), .par_bit(par_bit)
    );

    always_comb begin
        case (state)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = lsb;
            ST_PARITY: tx_line = par_bit;
            default:   tx_line = 1'b1;
        endcase
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic tx_line,
    input logic busy,
    input logic frame_done
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line);

    // R3
    start_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!tx_line && busy));

    // R2
    ready_low_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !in_ready);

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    // R7
    busy_fall_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (frame_done && in_ready));
endmodule

bind sertx_top sertx_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .tx_line(tx_line), .busy(busy), .frame_done(frame_done)
);

// File: tb/sertx_top_tb_top.sv
`timescale 1ns/1ps
module sertx_top_tb_top;
    localparam int TPB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_len8 = 1'b1;
    logic [1:0] cfg_parity = 2'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, tx_line, busy, frame_done;

    int vectors = 0;
    int fails = 0;
    logic tick_run = 1'b0;

    always #2.5 clk = ~clk;

    sertx_top #(.TICKS_PER_BIT(TPB)) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cfg_len8(cfg_len8),
        .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .in_valid(in_valid),
        .in_data(in_data), .in_ready(in_ready), .tx_line(tx_line),
        .busy(busy), .frame_done(frame_done)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick <= tick_run ? ($urandom_range(0, 2) != 0) : 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int stop_ticks(input logic [1:0] s);
        return (s == 2'd0) ? TPB : (s == 2'd1) ? TPB + TPB / 2 : 2 * TPB;
    endfunction

    function automatic logic exp_parity(input logic [7:0] d, input logic l8, input logic [1:0] p);
        logic ones;
        ones = ^(l8 ? d : {1'b0, d[6:0]});
        return (p == 2'd2) ? ~ones : ones;
    endfunction

    task automatic send(input logic [7:0] d, input logic l8, input logic [1:0] p,
                        input logic [1:0] s, input logic mess);
        logic exp_bits [0:10];
        int   n, hp, sidx, total, tc;
        n    = l8 ? 8 : 7;
        hp   = (p == 2'd1 || p == 2'd2) ? 1 : 0;
        sidx = 1 + n + hp;
        total = TPB * sidx + stop_ticks(s);
        exp_bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) if (i < n) exp_bits[1 + i] = d[i];
        if (hp == 1) exp_bits[1 + n] = exp_parity(d, l8, p);

        @(negedge clk);
        check("R1 ready before accept", {31'd0, in_ready}, 32'd1);
        in_valid = 1'b1; in_data = d; cfg_len8 = l8; cfg_parity = p; cfg_stop = s;
        @(posedge clk);
        @(negedge clk);
        // R2 / R3: start bit and busy right after the accept edge
        check("R3 start bit", {31'd0, tx_line}, 32'd0);
        check("R2 busy", {30'd0, busy, in_ready}, 32'd2);
        if (mess) begin
            // R2 / R8: disturb data, valid and configuration mid-frame
            in_valid = 1'b1; in_data = ~d;
            cfg_len8 = ~l8; cfg_parity = p + 2'd1; cfg_stop = s + 2'd1;
        end else begin
            in_valid = 1'b0;
        end
        tc = 0;
        while (tc < total) begin
            @(posedge clk);
            if (tick) begin
                tc++;
                @(negedge clk);
                if (tc % TPB == TPB / 2 && tc / TPB < sidx)
                    check(tc / TPB == 0 ? "R3 start" : (tc / TPB <= n ? "R4 data" : "R5 parity"),
                          {31'd0, tx_line}, {31'd0, exp_bits[tc / TPB]});
                if (tc == TPB * sidx + 4)
                    check("R6 stop level", {31'd0, tx_line}, 32'd1);
                if (tc == total - 1) begin
                    check("R6 still busy before last stop tick", {30'd0, busy, frame_done}, 32'd2);
                    in_valid = 1'b0;
                end
                if (tc == total)
                    check("R7 done/ready/idle", {28'd0, frame_done, in_ready, busy, tx_line}, 32'hD);
            end
        end
        @(negedge clk);
        check("R7 done pulse one cycle", {31'd0, frame_done}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", {28'd0, tx_line, in_ready, busy, frame_done}, 32'hC);
        tick_run = 1'b1;
        // directed corners
        send(8'hA5, 1'b1, 2'd0, 2'd0, 1'b0);   // R4 8 bits, no parity, 1 stop
        send(8'h80, 1'b0, 2'd1, 2'd1, 1'b0);   // R4 bit7 dropped, R5 even, R6 1.5 stop
        send(8'h00, 1'b1, 2'd2, 2'd2, 1'b0);   // R5 odd over zeros, R6 two stop
        send(8'hFF, 1'b0, 2'd3, 2'd3, 1'b1);   // R5 code 3 none, R6 code 3, R8 mid-frame changes
        send(8'h7F, 1'b1, 2'd1, 2'd1, 1'b1);   // R2 valid during busy ignored
        for (int k = 0; k < 120; k++)
            send(8'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
        // R1 idle after frames
        repeat (5) @(negedge clk);
        check("R1 idle line", {28'd0, tx_line, in_ready, busy, frame_done}, 32'hC);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule